// File: doc/BRIEF.md
# ASID-Tagged Multi-Size Translation Cache

This block is a small fully associative cache of completed leaf translations for a three-level, 39-bit virtual address scheme. Each entry remembers the address space identifier it was filled under and a global flag. It also keeps the virtual tag and the physical base, both already aligned to the page size, along with the attribute byte of the leaf and the physical location of that leaf in memory. Because the page size is stored per entry as a match mask, one entry can cover a 4 KiB page, a 2 MiB region or a 1 GiB region.

The lookup side is purely combinational. It takes an identifier and a virtual address, and in the same cycle returns whether a translation exists, the physical address, the attribute byte, the leaf's memory address and the entry index. A page walker outside the block writes new translations through the fill port. When a hit needs its accessed or dirty bits set, the external write-back logic uses the update port to rewrite the attribute byte of the entry it hit. The invalidate port can be narrowed by an identifier, by an address, by both or by neither, and the global flag is respected as required.

Top module: `asid_page_tlb`

## Requirements
- R1: After reset every entry is invalid, so no lookup hits until a fill has taken effect.
- R2: A lookup hits an entry that is valid when two conditions hold. The entry must be global or carry the lookup identifier. The lookup address, with the low offset bits of that entry's page size cleared, must equal the stored virtual tag.
- R3: The offset width of an entry is 12 + 9 × level, where level is the fill level and a level of 3 is treated as 2. At fill, the virtual tag and the physical base are stored with their offset bits cleared. The physical address of a hit is the stored base ORed with the lookup address's offset bits.
- R4: The lookup outputs (hit, physical address, attribute byte, leaf address and index) follow the lookup inputs in the same cycle. Fills, updates and invalidates change them only from the next rising clock edge.
- R5: When several entries hit, the outputs come from the lowest-numbered one.
- R6: A fill writes the lowest-numbered invalid entry. When every entry is valid, it writes the entry with the earliest fill time, and on a tie the lowest-numbered one.
- R7: An invalidate with neither qualifier clears every entry.
- R8: An invalidate qualified by address only clears every entry whose page contains that address, global entries included.
- R9: An invalidate qualified by identifier only clears the non-global entries of that identifier. Global entries and entries of other identifiers are kept.
- R10: An invalidate qualified by both clears only the non-global entries that carry that identifier and whose page contains that address.
- R11: An update replaces the attribute byte of the entry named by its index at the next edge and leaves the other fields of that entry as they were.
- R12: An invalidate in the same cycle as a fill or an update takes effect alone, and the fill or update is dropped. A fill and an update that target the same entry in one cycle leave the fill's contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_asid | input | 16 | Lookup address space identifier |
| lk_vaddr | input | 39 | Lookup virtual address |
| lk_hit | output | 1 | A valid entry matches |
| lk_paddr | output | 56 | Translated physical address |
| lk_attr | output | 8 | Attribute byte of the matching entry |
| lk_pte_addr | output | 56 | Memory address of the matching leaf |
| lk_index | output | 3 | Index of the matching entry |
| fill_en | input | 1 | Write a new translation |
| fill_asid | input | 16 | Identifier of the new translation |
| fill_global | input | 1 | New translation is global |
| fill_vaddr | input | 39 | Virtual address that was walked |
| fill_level | input | 2 | Level of the leaf (0 = 4 KiB, 1 = 2 MiB, 2 = 1 GiB) |
| fill_paddr | input | 56 | Physical address produced by the walk |
| fill_attr | input | 8 | Attribute byte of the leaf |
| fill_pte_addr | input | 56 | Memory address of the leaf |
| upd_en | input | 1 | Rewrite an entry's attribute byte |
| upd_index | input | 3 | Entry to rewrite |
| upd_attr | input | 8 | New attribute byte |
| flush_en | input | 1 | Invalidate request |
| flush_use_asid | input | 1 | Narrow the invalidate by identifier |
| flush_asid | input | 16 | Identifier qualifier |
| flush_use_addr | input | 1 | Narrow the invalidate by address |
| flush_vaddr | input | 39 | Address qualifier |

## Verification
The bench builds the block with its defaults: eight entries and a 32-bit fill-time counter. With eight entries the table fills after a handful of directed fills, so the oldest-entry replacement path and its tie rule are exercised often. The counter is wide enough that it never wraps within the run. Lookups, fills and invalidates draw from a pool of six address regions and three identifiers. With levels 0 to 3 mixed in, overlapping large and small pages, hits through the global flag and every invalidate qualifier combination occur many times during the random phase.

// File: rtl/asid_tlb_pkg.sv
`timescale 1ns/1ps
package asid_tlb_pkg;
  parameter int unsigned VA_W     = 39;
  parameter int unsigned PA_W     = 56;
  parameter int unsigned ASID_W   = 16;
  parameter int unsigned ATTR_W   = 8;
  parameter int unsigned OFS_BITS = 12;
  parameter int unsigned LVL_BITS = 9;
  parameter int unsigned LEVELS   = 3;
  localparam int unsigned LVL_W   = (LEVELS > 1) ? $clog2(LEVELS) : 1;
  localparam int unsigned TOP_LVL = LEVELS - 1;

  typedef struct packed {
    logic              valid;
    logic              glob;
    logic [ASID_W-1:0] asid;
    logic [VA_W-1:0]   vtag;
    logic [VA_W-1:0]   mmask;
    logic [PA_W-1:0]   pbase;
    logic [ATTR_W-1:0] attr;
    logic [PA_W-1:0]   pte_addr;
  } tlb_entry_t;
endpackage

// File: rtl/tlb_level_mask.sv
`timescale 1ns/1ps
module tlb_level_mask
  import asid_tlb_pkg::*;
(
  input  logic [LVL_W-1:0] level,
  output logic [VA_W-1:0]  sel_mask
);
  int unsigned lvl_c;
  int unsigned ofs_w;

  always_comb begin
    lvl_c = (int'(level) > int'(TOP_LVL)) ? TOP_LVL : int'(level);
    ofs_w = OFS_BITS + LVL_BITS * lvl_c;
    for (int b = 0; b < int'(VA_W); b++) begin
      sel_mask[b] = (b < int'(ofs_w));
    end
  end
endmodule

// File: rtl/tlb_entry_match.sv
`timescale 1ns/1ps
module tlb_entry_match
  import asid_tlb_pkg::*;
(
  input  logic              e_valid,
  input  logic              e_glob,
  input  logic [ASID_W-1:0] e_asid,
  input  logic [VA_W-1:0]   e_vtag,
  input  logic [VA_W-1:0]   e_mmask,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [VA_W-1:0]   lk_vaddr,
  input  logic              fl_use_asid,
  input  logic              fl_use_addr,
  input  logic [ASID_W-1:0] fl_asid,
  input  logic [VA_W-1:0]   fl_vaddr,
  output logic              hit,
  output logic              kill
);
  logic lk_addr_ok, lk_id_ok, fl_addr_ok, fl_id_ok;

  always_comb begin
    lk_addr_ok = ((lk_vaddr & e_mmask) == e_vtag);
    lk_id_ok   = e_glob || (e_asid == lk_asid);
    hit        = e_valid && lk_addr_ok && lk_id_ok;
    fl_addr_ok = ((fl_vaddr & e_mmask) == e_vtag);
    fl_id_ok   = !e_glob && (e_asid == fl_asid);
    unique case ({fl_use_asid, fl_use_addr})
      2'b00:   kill = 1'b1;
      2'b01:   kill = fl_addr_ok;
      2'b10:   kill = fl_id_ok;
      default: kill = fl_id_ok && fl_addr_ok;
    endcase
  end
endmodule

// File: rtl/tlb_victim_pick.sv
`timescale 1ns/1ps
module tlb_victim_pick #(
  parameter int unsigned N     = 8,
  parameter int unsigned AGE_W = 32,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]            valid,
  input  logic [N-1:0][AGE_W-1:0] ages,
  output logic [IDX_W-1:0]        pick
);
  logic             found;
  logic [AGE_W-1:0] best;

  always_comb begin
    found = 1'b0;
    pick  = '0;
    best  = ages[0];
    for (int i = 0; i < int'(N); i++) begin
      if (!found && !valid[i]) begin
        found = 1'b1;
        pick  = IDX_W'(i);
      end
    end
    if (!found) begin
      for (int i = 1; i < int'(N); i++) begin
        if (ages[i] < best) begin
          best = ages[i];
          pick = IDX_W'(i);
        end
      end
    end
  end
endmodule

// File: rtl/asid_page_tlb.sv
`timescale 1ns/1ps
module asid_page_tlb
  import asid_tlb_pkg::*;
#(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned AGE_W   = 32,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [VA_W-1:0]   lk_vaddr,
  output logic              lk_hit,
  output logic [PA_W-1:0]   lk_paddr,
  output logic [ATTR_W-1:0] lk_attr,
  output logic [PA_W-1:0]   lk_pte_addr,
  output logic [IDX_W-1:0]  lk_index,
  input  logic              fill_en,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic              fill_global,
  input  logic [VA_W-1:0]   fill_vaddr,
  input  logic [LVL_W-1:0]  fill_level,
  input  logic [PA_W-1:0]   fill_paddr,
  input  logic [ATTR_W-1:0] fill_attr,
  input  logic [PA_W-1:0]   fill_pte_addr,
  input  logic              upd_en,
  input  logic [IDX_W-1:0]  upd_index,
  input  logic [ATTR_W-1:0] upd_attr,
  input  logic              flush_en,
  input  logic              flush_use_asid,
  input  logic [ASID_W-1:0] flush_asid,
  input  logic              flush_use_addr,
  input  logic [VA_W-1:0]   flush_vaddr
);
  localparam int unsigned PAD_W = PA_W - VA_W;

  tlb_entry_t                    ent_q [ENTRIES];
  tlb_entry_t                    ent_d [ENTRIES];
  logic [ENTRIES-1:0][AGE_W-1:0] age_q, age_d;
  logic [AGE_W-1:0]              cyc_q, cyc_d;
  logic [ENTRIES-1:0]            valid_vec, glob_vec, hit_vec, kill_vec;
  logic [VA_W-1:0]               fill_sel;
  logic [IDX_W-1:0]              victim, hit_idx;
  logic                          ent_we;
  tlb_entry_t                    hit_ent;

  // Page-size mask of the incoming translation
  tlb_level_mask u_fill_mask (
    .level    (fill_level),
    .sel_mask (fill_sel)
  );

  // Per-entry lookup and invalidate comparators
  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    assign valid_vec[g] = ent_q[g].valid;
    assign glob_vec[g]  = ent_q[g].glob;
    tlb_entry_match u_match (
      .e_valid     (ent_q[g].valid),
      .e_glob      (ent_q[g].glob),
      .e_asid      (ent_q[g].asid),
      .e_vtag      (ent_q[g].vtag),
      .e_mmask     (ent_q[g].mmask),
      .lk_asid     (lk_asid),
      .lk_vaddr    (lk_vaddr),
      .fl_use_asid (flush_use_asid),
      .fl_use_addr (flush_use_addr),
      .fl_asid     (flush_asid),
      .fl_vaddr    (flush_vaddr),
      .hit         (hit_vec[g]),
      .kill        (kill_vec[g])
    );
  end

  tlb_victim_pick #(.N(ENTRIES), .AGE_W(AGE_W)) u_victim (
    .valid (valid_vec),
    .ages  (age_q),
    .pick  (victim)
  );

  // Lowest-index hit wins
  always_comb begin
    hit_idx = '0;
    for (int i = int'(ENTRIES) - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_idx = IDX_W'(i);
    end
    hit_ent     = ent_q[hit_idx];
    lk_hit      = |hit_vec;
    lk_index    = hit_idx;
    lk_attr     = hit_ent.attr;
    lk_pte_addr = hit_ent.pte_addr;
    lk_paddr    = hit_ent.pbase | {{PAD_W{1'b0}}, (lk_vaddr & ~hit_ent.mmask)};
  end

  // Next state
  always_comb begin
    ent_d  = ent_q;
    age_d  = age_q;
    cyc_d  = cyc_q + 1'b1;
    ent_we = flush_en || fill_en || upd_en;
    if (flush_en) begin
      for (int i = 0; i < int'(ENTRIES); i++) begin
        if (kill_vec[i]) ent_d[i].valid = 1'b0;
      end
    end else begin
      if (upd_en) ent_d[upd_index].attr = upd_attr;
      if (fill_en) begin
        ent_d[victim].valid    = 1'b1;
        ent_d[victim].glob     = fill_global;
        ent_d[victim].asid     = fill_asid;
        ent_d[victim].vtag     = fill_vaddr & ~fill_sel;
        ent_d[victim].mmask    = ~fill_sel;
        ent_d[victim].pbase    = fill_paddr & ~{{PAD_W{1'b0}}, fill_sel};
        ent_d[victim].attr     = fill_attr;
        ent_d[victim].pte_addr = fill_pte_addr;
        age_d[victim]          = cyc_q;
      end
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q <= '0;
      age_q <= '0;
      for (int i = 0; i < int'(ENTRIES); i++) ent_q[i] <= '0;
    end else begin
      cyc_q <= cyc_d;
      if (ent_we) begin
        ent_q <= ent_d;
        age_q <= age_d;
      end
    end
  end

  AST_RESET_EMPTY: assert property (@(posedge clk) $rose(rst_n) |-> valid_vec == '0); // R1
  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_paddr[OFS_BITS-1:0] == lk_vaddr[OFS_BITS-1:0]); // R3
  AST_LOWEST_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> hit_vec[lk_index] && ((hit_vec & ((ENTRIES'(1) << lk_index) - 1'b1)) == '0)); // R5
  AST_VICTIM_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    !(&valid_vec) |-> !valid_vec[victim]); // R6
  AST_FILL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en && !flush_en |=> valid_vec[$past(victim)] && ent_q[$past(victim)].attr == $past(fill_attr)); // R6
  AST_FLUSH_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    flush_en && !flush_use_asid && !flush_use_addr |=> valid_vec == '0); // R7
  AST_GLOBAL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    flush_en && flush_use_asid |=> (valid_vec & glob_vec) == $past(valid_vec & glob_vec)); // R9
  AST_FLUSH_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    flush_en |=> (valid_vec & ~$past(valid_vec)) == '0); // R12
endmodule

// File: tb/asid_page_tlb_tb_top.sv
`timescale 1ns/1ps
module asid_page_tlb_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] lk_asid = '0;
  logic [38:0] lk_vaddr = '0;
  logic        lk_hit;
  logic [55:0] lk_paddr, lk_pte_addr;
  logic [7:0]  lk_attr;
  logic [2:0]  lk_index;
  logic        fill_en = 1'b0, fill_global = 1'b0;
  logic [15:0] fill_asid = '0;
  logic [38:0] fill_vaddr = '0;
  logic [1:0]  fill_level = '0;
  logic [55:0] fill_paddr = '0, fill_pte_addr = '0;
  logic [7:0]  fill_attr = '0, upd_attr = '0;
  logic        upd_en = 1'b0;
  logic [2:0]  upd_index = '0;
  logic        flush_en = 1'b0, flush_use_asid = 1'b0, flush_use_addr = 1'b0;
  logic [15:0] flush_asid = '0;
  logic [38:0] flush_vaddr = '0;

  asid_page_tlb dut_i (.*);

  always #10 clk = ~clk;

  // Behavioural reference state
  bit          m_v [8];
  bit          m_g [8];
  logic [15:0] m_asid [8];
  logic [63:0] m_va [8], m_sm [8], m_pa [8];
  logic [7:0]  m_attr [8];
  logic [55:0] m_pta [8];
  longint      m_age [8];
  longint      seq = 0;
  int          nchk = 0, nerr = 0;
  bit          done = 1'b0;
  string       cur_req = "R1";
  logic [38:0] pool [6];
  logic [15:0] ids [3] = '{16'h0001, 16'h0002, 16'h00A5};

  function automatic logic [63:0] sel_of(int lvl);
    int l = (lvl > 2) ? 2 : lvl;
    return (64'd1 << (12 + 9 * l)) - 64'd1;
  endfunction

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    int hi = -1;
    for (int i = 7; i >= 0; i--)
      if (m_v[i] && (m_g[i] || m_asid[i] == lk_asid) && ((64'(lk_vaddr) & ~m_sm[i]) == m_va[i]))
        hi = i;
    check(cur_req, "hit", 64'(lk_hit), 64'(hi >= 0));
    if (hi >= 0) begin
      check(cur_req, "paddr", 64'(lk_paddr), m_pa[hi] | (64'(lk_vaddr) & m_sm[hi]));
      check(cur_req, "attr", 64'(lk_attr), 64'(m_attr[hi]));
      check(cur_req, "pte_addr", 64'(lk_pte_addr), 64'(m_pta[hi]));
      check(cur_req, "index", 64'(lk_index), 64'(hi));
    end
  endtask

  task automatic model_edge();
    int vic = -1;
    for (int i = 0; i < 8; i++) if (vic < 0 && !m_v[i]) vic = i;
    if (vic < 0) begin
      vic = 0;
      for (int i = 1; i < 8; i++) if (m_age[i] < m_age[vic]) vic = i;
    end
    if (flush_en) begin
      for (int i = 0; i < 8; i++) begin
        bit a_ok = ((64'(flush_vaddr) & ~m_sm[i]) == m_va[i]);
        bit i_ok = !m_g[i] && (m_asid[i] == flush_asid);
        bit k = !flush_use_asid && !flush_use_addr ? 1'b1 :
                !flush_use_asid ? a_ok : !flush_use_addr ? i_ok : (a_ok && i_ok);
        if (k) m_v[i] = 1'b0;
      end
    end else begin
      if (upd_en) m_attr[upd_index] = upd_attr;
      if (fill_en) begin
        m_v[vic]    = 1'b1;
        m_g[vic]    = fill_global;
        m_asid[vic] = fill_asid;
        m_sm[vic]   = sel_of(int'(fill_level));
        m_va[vic]   = 64'(fill_vaddr) & ~m_sm[vic];
        m_pa[vic]   = 64'(fill_paddr) & ~m_sm[vic];
        m_attr[vic] = fill_attr;
        m_pta[vic]  = fill_pte_addr;
        m_age[vic]  = seq++;
      end
    end
  endtask

  // Called just after a falling edge with inputs set
  task automatic tick();
    #2 compare();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    fill_en = 1'b0; upd_en = 1'b0; flush_en = 1'b0;
  endtask

  task automatic do_fill(logic [15:0] a, bit g, logic [38:0] va, int lvl, logic [55:0] pa, logic [7:0] at);
    fill_en = 1'b1; fill_asid = a; fill_global = g; fill_vaddr = va; fill_level = 2'(lvl);
    fill_paddr = pa; fill_attr = at; fill_pte_addr = pa ^ 56'h0ABC_0000_0008;
    tick();
  endtask

  task automatic do_look(logic [15:0] a, logic [38:0] va);
    lk_asid = a; lk_vaddr = va;
    tick();
  endtask

  task automatic do_flush(bit ua, logic [15:0] a, bit uv, logic [38:0] va);
    flush_en = 1'b1; flush_use_asid = ua; flush_asid = a; flush_use_addr = uv; flush_vaddr = va;
    tick();
  endtask

  task automatic probe_pool(logic [15:0] a);
    for (int k = 0; k < 6; k++) do_look(a, pool[k] ^ 39'h0_0000_0123);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 6; k++) pool[k] = 39'({$urandom(), $urandom()});
    for (int i = 0; i < 8; i++) begin
      m_v[i] = 1'b0; m_g[i] = 1'b0; m_asid[i] = '0; m_va[i] = '0; m_sm[i] = '0;
      m_pa[i] = '0; m_attr[i] = '0; m_pta[i] = '0; m_age[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: empty after reset
    cur_req = "R1";
    do_look(ids[0], pool[0]);
    do_look(ids[1], 39'h0);
    // R3 / R4: one entry of each size, then lookups at several offsets
    cur_req = "R3";
    do_fill(ids[0], 1'b0, pool[0], 0, 56'h12_3456_789A_BCDE, 8'hC3);
    do_fill(ids[0], 1'b0, pool[1], 1, 56'h00_FFFF_FFFF_FFFF, 8'h47);
    do_fill(ids[1], 1'b1, pool[2], 2, 56'hA5_A5A5_A5A5_A5A5, 8'hCF);
    do_fill(ids[2], 1'b0, pool[3], 3, 56'h01_0203_0405_0607, 8'h0B);
    cur_req = "R4";
    for (int k = 0; k < 4; k++) begin
      do_look(ids[0], pool[k] ^ 39'h0_0000_0FFF);
      do_look(ids[0], pool[k] ^ 39'h0_001F_F000);
      do_look(ids[0], pool[k] ^ 39'h0_3FE0_0000);
    end
    // R2: identifier mismatch and global entries
    cur_req = "R2";
    probe_pool(ids[1]);
    probe_pool(ids[2]);
    // R5: overlapping large and small pages
    cur_req = "R5";
    do_fill(ids[0], 1'b0, pool[4], 2, 56'h11_0000_0000_0000, 8'h11);
    do_fill(ids[0], 1'b0, pool[4], 0, 56'h22_0000_0000_0000, 8'h22);
    do_look(ids[0], pool[4]);
    do_look(ids[0], pool[4] ^ 39'h0_0010_0000);
    // R6: overfill the table
    cur_req = "R6";
    for (int n = 0; n < 6; n++) begin
      do_fill(ids[n % 3], n[0], pool[5] ^ 39'(n << 12), 0, 56'(n) << 20, 8'(n + 8'h60));
      do_look(ids[n % 3], pool[5] ^ 39'(n << 12));
    end
    probe_pool(ids[0]);
    // R11: attribute rewrite through the update port
    cur_req = "R11";
    for (int n = 0; n < 8; n++) begin
      upd_en = 1'b1; upd_index = 3'(n); upd_attr = 8'(8'hE0 + n);
      tick();
      do_look(ids[n % 3], pool[5] ^ 39'(n << 12));
    end
    // R12: conflicts in one cycle
    cur_req = "R12";
    fill_en = 1'b1; fill_asid = ids[0]; fill_vaddr = pool[1]; fill_level = 2'd1;
    fill_paddr = 56'h33_0000_0000_0000; fill_attr = 8'h77; fill_global = 1'b0;
    upd_en = 1'b1; upd_index = 3'd0; upd_attr = 8'h99;
    flush_en = 1'b1; flush_use_asid = 1'b1; flush_asid = ids[2]; flush_use_addr = 1'b0;
    tick();
    probe_pool(ids[0]);
    fill_en = 1'b1; upd_en = 1'b1; upd_index = 3'd0; upd_attr = 8'h5A; fill_attr = 8'hA5;
    for (int i = 0; i < 8; i++) if (m_age[i] < m_age[upd_index] && m_v[i]) upd_index = 3'(i);
    tick();
    probe_pool(ids[0]);
    // R8 .. R10 / R7: the four invalidate forms
    cur_req = "R8";
    do_flush(1'b0, '0, 1'b1, pool[2]);
    probe_pool(ids[1]);
    do_fill(ids[1], 1'b1, pool[2], 2, 56'h44_0000_0000_0000, 8'h01);
    cur_req = "R9";
    do_flush(1'b1, ids[1], 1'b0, '0);
    probe_pool(ids[1]);
    probe_pool(ids[0]);
    cur_req = "R10";
    do_fill(ids[0], 1'b0, pool[3], 1, 56'h55_0000_0000_0000, 8'h02);
    do_flush(1'b1, ids[0], 1'b1, pool[3]);
    probe_pool(ids[0]);
    do_flush(1'b1, ids[1], 1'b1, pool[2]);
    probe_pool(ids[1]);
    cur_req = "R7";
    do_flush(1'b0, '0, 1'b0, '0);
    probe_pool(ids[0]);
    // Mixed random traffic (R2 lookups against all of the above)
    cur_req = "R2";
    for (int n = 0; n < 4000; n++) begin
      int r = int'($urandom_range(0, 99));
      lk_asid  = ids[$urandom_range(0, 2)];
      lk_vaddr = pool[$urandom_range(0, 5)] ^ 39'($urandom_range(0, 32'h3F_FFFF));
      fill_en = (r < 22) || (r >= 96);
      fill_asid = ids[$urandom_range(0, 2)]; fill_global = ($urandom_range(0, 5) == 0);
      fill_vaddr = pool[$urandom_range(0, 5)] ^ 39'($urandom_range(0, 32'h3F_FFFF));
      fill_level = 2'($urandom_range(0, 3)); fill_paddr = 56'({$urandom(), $urandom()});
      fill_attr = 8'($urandom()); fill_pte_addr = 56'({$urandom(), $urandom()});
      upd_en = (r >= 22 && r < 32) || (r >= 98);
      upd_index = 3'($urandom_range(0, 7)); upd_attr = 8'($urandom());
      flush_en = (r >= 32 && r < 36) || (r >= 96);
      flush_use_asid = $urandom_range(0, 1) == 1; flush_use_addr = $urandom_range(0, 1) == 1;
      flush_asid = ids[$urandom_range(0, 2)];
      flush_vaddr = pool[$urandom_range(0, 5)] ^ 39'($urandom_range(0, 32'h3F_FFFF));
      tick();
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule